// File: doc/BRIEF.md
# Boot ROM Bank Access Controller

This block connects a system bus request port to an external ROM or flash part that holds boot code. It claims the top 16 Mbytes of the 32-bit address space, splits that window into two 8-Mbyte banks and drives one chip select per bank. It also produces the ROM word address and the read and write strobes. Every access is timed by a down-counter. The counter is loaded from a base latency that depends on the transfer, plus a programmable number of wait states.

Reads may be issued as four-beat bursts. The first beat uses the first-access wait field. Each later beat uses the shorter beat wait field, but only when burst timing has been enabled in the configuration register. Reset loads both wait fields with their largest values and clears the enable bit, so the first fetches after power-up meet the slowest device. Boot code then writes tighter values through the configuration port.

A strap input picks the data bus width. The width sets how the byte address is folded into ROM word-address bits.

Top module: `rom_bank_ctrl`

## Requirements
- R1: An access to any byte in 0xFF800000..0xFFFFFFFF asserts `rom_cs[0]` alone for the whole access.
- R2: An access to any byte in 0xFF000000..0xFF7FFFFF asserts `rom_cs[1]` alone for the whole access.
- R3: An access below 0xFF000000 asserts no chip select and no `beat_ack`. Instead `err_ack` is high for exactly one cycle, in the first cycle after the request is accepted.
- R4: A read of size code 01 (32-bit) or 10/11 (64-bit) has `beat_ack` in cycle 3 + F after acceptance. F is `cfg_wdata[4:0]`, the first-access wait count.
- R5: A read of size code 00 (8-bit) has `beat_ack` in cycle 2 + F after acceptance.
- R6: A write has `beat_ack` in cycle 2 after acceptance whatever the wait fields hold. It asserts `rom_we` and never `rom_oe`. It is always a single beat, even when `req_burst` is set.
- R7: With the burst enable bit `cfg_wdata[9]` set, a burst read returns 4 beats. The first beat comes F cycles after the R4/R5 base. Each later beat comes 2 + B cycles after the previous one, where B is `cfg_wdata[8:5]`. `beat_last` is high only with the fourth beat.
- R8: With the burst enable bit clear, every beat of a burst read takes the full first-access latency of R4/R5.
- R9: After reset, `cfg_rdata` reads 0x1FF (F = 31, B = 15, enable clear), no chip select is asserted and `req_ready` is high.
- R10: With `bus32` low, `rom_addr` is {0, addr[22:3]}. With `bus32` high, `rom_addr` is addr[22:2], so bit 20 carries addr[22].
- R11: The beats of a burst carry `rom_addr` values base, base+1, base+2, base+3. The base is the start address with its two low word bits cleared.
- R12: During a burst, the chip select and `rom_oe` stay asserted between beats. They deassert in the cycle after the final `beat_ack`.
- R13: A configuration write made while an access is in progress leaves that access's timing unchanged and applies from the next access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus32 | input | 1 | Strap: 1 = 32-bit ROM data bus, 0 = 64-bit |
| req_valid | input | 1 | Access request |
| req_ready | output | 1 | Controller idle; request accepted when both are high |
| req_addr | input | 32 | Byte address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 00 = 8-bit, 01 = 32-bit, 10/11 = 64-bit |
| req_burst | input | 1 | 1 = four-beat burst read |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 10 | [4:0] first wait, [8:5] beat wait, [9] burst enable |
| cfg_rdata | output | 10 | Current configuration, same layout |
| rom_cs | output | 2 | Bank chip selects, active high |
| rom_addr | output | 21 | ROM word address |
| rom_oe | output | 1 | Output enable, active high |
| rom_we | output | 1 | Write enable, active high |
| beat_ack | output | 1 | Data beat complete |
| beat_last | output | 1 | Qualifies `beat_ack` as the final beat |
| err_ack | output | 1 | Unmapped address acknowledge |

## Verification
The bench probes the bank boundaries on both sides: 0xFF7FFFFF against 0xFF800000, and 0xFEFFFFFF against 0xFF000000. An off-by-one tag compare would select the wrong bank there, or answer an unmapped address with a real strobe. It measures latency with the wait fields at zero, at mid values and at the all-ones reset values. An adder that drops the base, or that applies the wait fields to writes, shows up as a wrong ack cycle. Bursts run once with the enable set and once with it clear, so a controller that ignores the enable, or that counts the first beat with the beat field, lands its acks early. A configuration write dropped into the middle of a read catches a design that reads the live register instead of a per-access snapshot.

// File: rtl/rom_bank_pkg.sv
package rom_bank_pkg;

    localparam int FW_W       = 5;
    localparam int BW_W       = 4;
    localparam int WIDE_BASE  = 3;
    localparam int BYTE_BASE  = 2;
    localparam int WRITE_LAT  = 2;
    localparam int BEAT_BASE  = 2;
    localparam int CNT_W      = $clog2(WIDE_BASE + (1 << FW_W));

    localparam logic [1:0] SZ_BYTE = 2'b00;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACCESS = 2'd1,
        ST_ERROR  = 2'd2
    } st_e;

    typedef struct packed {
        logic            burst_en;
        logic [BW_W-1:0] beat_wait;
        logic [FW_W-1:0] first_wait;
    } cfg_t;

    localparam int CFG_W = $bits(cfg_t);

endpackage

// File: rtl/rom_cfg_regs.sv
module rom_cfg_regs
    import rom_bank_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CFG_W-1:0] wr_data,
    output cfg_t             cfg
);

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) begin
            cfg_d = cfg_t'(wr_data);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q.burst_en   <= 1'b0;
            cfg_q.beat_wait  <= '1;
            cfg_q.first_wait <= '1;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign cfg = cfg_q;

endmodule

// File: rtl/rom_bank_decode.sv
module rom_bank_decode #(
    parameter int ADDR_W    = 32,
    parameter int BANK_LOG2 = 23,
    parameter int NUM_BANKS = 2
) (
    input  logic [ADDR_W-BANK_LOG2-1:0] tag,
    output logic [NUM_BANKS-1:0]        sel,
    output logic                        hit
);

    localparam int TAG_W = ADDR_W - BANK_LOG2;
    localparam logic [TAG_W-1:0] TOP_TAG = '1;

    // Bank 0 owns the highest slice, each following bank the slice below it.
    for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
        localparam logic [TAG_W-1:0] MY_TAG = TOP_TAG - TAG_W'(i);
        assign sel[i] = (tag == MY_TAG);
    end

    assign hit = |sel;

endmodule

// File: rtl/rom_latency.sv
module rom_latency
    import rom_bank_pkg::*;
(
    input  cfg_t             cfg,
    input  logic             is_write,
    input  logic [1:0]       size,
    output logic [CNT_W-1:0] first_lat,
    output logic [CNT_W-1:0] later_lat
);

    logic [CNT_W-1:0] read_base;
    logic [CNT_W-1:0] read_lat;

    always_comb begin
        read_base = (size == SZ_BYTE) ? CNT_W'(BYTE_BASE) : CNT_W'(WIDE_BASE);
        read_lat  = read_base + CNT_W'(cfg.first_wait);
        first_lat = is_write ? CNT_W'(WRITE_LAT) : read_lat;
        later_lat = cfg.burst_en ? (CNT_W'(BEAT_BASE) + CNT_W'(cfg.beat_wait))
                                 : read_lat;
    end

endmodule

// File: rtl/rom_bank_ctrl.sv
module rom_bank_ctrl
    import rom_bank_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int BANK_LOG2 = 23,
    parameter int NUM_BANKS = 2,
    parameter int BEATS     = 4,
    localparam int RA_W     = BANK_LOG2 - 2,
    localparam int TAG_W    = ADDR_W - BANK_LOG2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus32,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic                 req_write,
    input  logic [1:0]           req_size,
    input  logic                 req_burst,
    input  logic                 cfg_we,
    input  logic [CFG_W-1:0]     cfg_wdata,
    output logic [CFG_W-1:0]     cfg_rdata,
    output logic [NUM_BANKS-1:0] rom_cs,
    output logic [RA_W-1:0]      rom_addr,
    output logic                 rom_oe,
    output logic                 rom_we,
    output logic                 beat_ack,
    output logic                 beat_last,
    output logic                 err_ack
);

    localparam int BEAT_W = (BEATS > 1) ? $clog2(BEATS) : 1;
    localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BEATS - 1);

    typedef struct packed {
        st_e                  st;
        logic [CNT_W-1:0]     cnt;
        logic [BEAT_W-1:0]    beat;
        logic                 burst;
        logic                 wr;
        logic [NUM_BANKS-1:0] cs;
        logic [RA_W-1:0]      ra;
        logic [CNT_W-1:0]     later;
    } ctl_t;

    ctl_t s_d, s_q;

    cfg_t                 cfg;
    logic [NUM_BANKS-1:0] bank_sel;
    logic                 bank_hit;
    logic [CNT_W-1:0]     first_lat;
    logic [CNT_W-1:0]     later_lat;
    logic [RA_W-1:0]      start_ra;
    logic                 is_burst;
    logic                 at_zero;
    logic                 final_beat;
    logic                 unused_addr_bits;

    rom_cfg_regs u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we),
        .wr_data (cfg_wdata),
        .cfg     (cfg)
    );

    rom_bank_decode #(
        .ADDR_W    (ADDR_W),
        .BANK_LOG2 (BANK_LOG2),
        .NUM_BANKS (NUM_BANKS)
    ) u_dec (
        .tag (req_addr[ADDR_W-1:BANK_LOG2]),
        .sel (bank_sel),
        .hit (bank_hit)
    );

    rom_latency u_lat (
        .cfg       (cfg),
        .is_write  (req_write),
        .size      (req_size),
        .first_lat (first_lat),
        .later_lat (later_lat)
    );

    assign unused_addr_bits = ^req_addr[1:0];

    // Fold the byte address into word address bits for the selected bus width.
    always_comb begin
        if (bus32) begin
            start_ra = req_addr[BANK_LOG2-1:2];
        end else begin
            start_ra = {1'b0, req_addr[BANK_LOG2-1:3]};
        end
        is_burst = req_burst && !req_write;
        if (is_burst) begin
            start_ra[BEAT_W-1:0] = '0;
        end
    end

    assign at_zero    = (s_q.cnt == '0);
    assign final_beat = !s_q.burst || (s_q.beat == LAST_BEAT);

    always_comb begin
        s_d = s_q;
        unique case (s_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    if (bank_hit) begin
                        s_d.st    = ST_ACCESS;
                        s_d.cs    = bank_sel;
                        s_d.wr    = req_write;
                        s_d.burst = is_burst;
                        s_d.beat  = '0;
                        s_d.cnt   = first_lat - CNT_W'(1);
                        s_d.later = later_lat;
                        s_d.ra    = start_ra;
                    end else begin
                        s_d.st = ST_ERROR;
                        s_d.cs = '0;
                    end
                end
            end
            ST_ACCESS: begin
                if (!at_zero) begin
                    s_d.cnt = s_q.cnt - CNT_W'(1);
                end else if (final_beat) begin
                    s_d.st = ST_IDLE;
                    s_d.cs = '0;
                end else begin
                    s_d.beat              = s_q.beat + BEAT_W'(1);
                    s_d.ra[BEAT_W-1:0]    = s_q.beat + BEAT_W'(1);
                    s_d.cnt               = s_q.later - CNT_W'(1);
                end
            end
            ST_ERROR: begin
                s_d.st = ST_IDLE;
            end
            default: begin
                s_d.st = ST_IDLE;
                s_d.cs = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: ST_IDLE, default: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign req_ready = (s_q.st == ST_IDLE);
    assign cfg_rdata = cfg;
    assign rom_cs    = s_q.cs;
    assign rom_addr  = s_q.ra;
    assign rom_oe    = (s_q.st == ST_ACCESS) && !s_q.wr;
    assign rom_we    = (s_q.st == ST_ACCESS) && s_q.wr;
    assign beat_ack  = (s_q.st == ST_ACCESS) && at_zero;
    assign beat_last = beat_ack && final_beat;
    assign err_ack   = (s_q.st == ST_ERROR);

endmodule

// File: rtl/rom_bank_ctrl_sva.sv
module rom_bank_ctrl_sva #(
    parameter int NUM_BANKS = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 req_ready,
    input logic [NUM_BANKS-1:0] rom_cs,
    input logic                 rom_oe,
    input logic                 rom_we,
    input logic                 beat_ack,
    input logic                 beat_last,
    input logic                 err_ack
);

    AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rom_cs)); // R1

    AST_ACK_WITH_CS: assert property (@(posedge clk) disable iff (!rst_n)
        beat_ack |-> (rom_cs != '0)); // R2

    AST_ERR_NO_CS: assert property (@(posedge clk) disable iff (!rst_n)
        err_ack |-> (rom_cs == '0 && !beat_ack)); // R3

    AST_ERR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        err_ack |=> !err_ack); // R3

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(rom_oe && rom_we)); // R6

    AST_WRITE_TWO_CYCLES: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rom_we) |=> (beat_ack && beat_last)); // R6

    AST_BURST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_ack && !beat_last) |=> (rom_cs == $past(rom_cs) && rom_oe)); // R12

    AST_RELEASE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_ack && beat_last) |=> (rom_cs == '0 && !rom_oe && !rom_we)); // R12

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (rom_cs == '0 && !beat_ack)); // R9

endmodule

bind rom_bank_ctrl rom_bank_ctrl_sva #(
    .NUM_BANKS (NUM_BANKS)
) u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .rom_cs    (rom_cs),
    .rom_oe    (rom_oe),
    .rom_we    (rom_we),
    .beat_ack  (beat_ack),
    .beat_last (beat_last),
    .err_ack   (err_ack)
);

// File: tb/rom_bank_ctrl_tb.sv
`timescale 1ns/1ps
module rom_bank_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus32 = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic [1:0]  req_size = 2'b01;
    logic        req_burst = 1'b0;
    logic        cfg_we = 1'b0;
    logic [9:0]  cfg_wdata = '0;
    logic [9:0]  cfg_rdata;
    logic [1:0]  rom_cs;
    logic [20:0] rom_addr;
    logic        rom_oe, rom_we, beat_ack, beat_last, err_ack;

    always #2.5 clk = ~clk;

    rom_bank_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .bus32(bus32),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_write(req_write), .req_size(req_size), .req_burst(req_burst),
        .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .rom_cs(rom_cs), .rom_addr(rom_addr), .rom_oe(rom_oe), .rom_we(rom_we),
        .beat_ack(beat_ack), .beat_last(beat_last), .err_ack(err_ack)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    int          r_lat  [4];
    logic [20:0] r_ra   [4];
    logic [1:0]  r_cs   [4];
    logic        r_last [4];
    logic        r_oe   [4];
    logic        r_we   [4];
    int          r_beats;
    logic        r_err;
    logic [1:0]  r_err_cs;
    logic        r_held;
    logic        r_drop;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [9:0] v);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Issues one request and records each beat as seen at the ports.
    task automatic run_access(input logic [31:0] a, input logic wr, input logic [1:0] sz,
                              input logic bst, input logic mid_we, input logic [9:0] mid_d);
        int k;
        int since;
        bit fin;
        r_beats = 0; r_err = 1'b0; r_err_cs = '0; r_held = 1'b1; r_drop = 1'b0;
        for (int i = 0; i < 4; i++) begin
            r_lat[i] = 0; r_ra[i] = '0; r_cs[i] = '0; r_last[i] = 1'b0;
            r_oe[i] = 1'b0; r_we[i] = 1'b0;
        end
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_write = wr; req_size = sz; req_burst = bst;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        k = 1; since = 1; fin = 1'b0;
        while (!fin && k < 300) begin
            cfg_we = (mid_we && k == 1);
            cfg_wdata = mid_d;
            if (err_ack) begin
                r_err = 1'b1; r_err_cs = rom_cs; fin = 1'b1;
            end else begin
                if (rom_cs == '0 || (!wr && !rom_oe)) r_held = 1'b0;
                if (beat_ack && r_beats < 4) begin
                    r_lat[r_beats] = since; r_ra[r_beats] = rom_addr;
                    r_cs[r_beats] = rom_cs; r_last[r_beats] = beat_last;
                    r_oe[r_beats] = rom_oe; r_we[r_beats] = rom_we;
                    r_beats++;
                    since = 0;
                    if (beat_last) fin = 1'b1;
                end
            end
            if (!fin) begin
                @(negedge clk);
                k++; since++;
            end
        end
        cfg_we = 1'b0;
        if (!fin) chk(1'b0, "access timeout", k, 0);
        @(negedge clk);
        r_drop = (rom_cs == '0) && !rom_oe && !rom_we;
    endtask

    function automatic logic [20:0] exp_ra(input logic [31:0] a, input logic b32);
        return b32 ? a[22:2] : {1'b0, a[22:3]};
    endfunction

    typedef struct packed {
        logic [9:0]  cfg;
        logic [31:0] addr;
        logic        wr;
        logic [1:0]  sz;
        logic        b32;
        logic [1:0]  cs;
        logic        err;
        logic [7:0]  lat;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{10'h000, 32'hFF800000, 1'b0, 2'b01, 1'b0, 2'b01, 1'b0, 8'd3},  // R1 R4
        '{10'h000, 32'hFF000000, 1'b0, 2'b10, 1'b0, 2'b10, 1'b0, 8'd3},  // R2 R4
        '{10'h000, 32'hFFFFFFFC, 1'b0, 2'b00, 1'b0, 2'b01, 1'b0, 8'd2},  // R1 R5
        '{10'h000, 32'hFF7FFFF0, 1'b1, 2'b01, 1'b0, 2'b10, 1'b0, 8'd2},  // R2 R6
        '{10'h004, 32'hFFC00000, 1'b0, 2'b01, 1'b1, 2'b01, 1'b0, 8'd7},  // R4 R10
        '{10'h004, 32'hFF400001, 1'b0, 2'b00, 1'b1, 2'b10, 1'b0, 8'd6},  // R5 R10
        '{10'h01F, 32'hFF800040, 1'b1, 2'b10, 1'b0, 2'b01, 1'b0, 8'd2},  // R6
        '{10'h000, 32'h00001000, 1'b0, 2'b01, 1'b0, 2'b00, 1'b1, 8'd1},  // R3
        '{10'h000, 32'hFEFFFFFF, 1'b0, 2'b00, 1'b0, 2'b00, 1'b1, 8'd1},  // R3
        '{10'h001, 32'hFF7FFFFF, 1'b0, 2'b00, 1'b1, 2'b10, 1'b0, 8'd3},  // R2 R5
        '{10'h01F, 32'hFFFFFFF8, 1'b0, 2'b10, 1'b0, 2'b01, 1'b0, 8'd34}  // R4
    };

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: reset values
        chk(cfg_rdata == 10'h1FF, "R9 cfg reset", cfg_rdata, 10'h1FF);
        chk(rom_cs == 2'b00, "R9 cs idle", rom_cs, 0);
        chk(req_ready == 1'b1, "R9 ready", req_ready, 1);
        // R9 R4: slowest timing straight out of reset
        run_access(32'hFF800000, 1'b0, 2'b01, 1'b0, 1'b0, '0);
        chk(r_lat[0] == 34, "R9 R4 reset latency", r_lat[0], 34);

        for (int v = 0; v < NV; v++) begin
            cfg_write(VECS[v].cfg);
            bus32 = VECS[v].b32;
            run_access(VECS[v].addr, VECS[v].wr, VECS[v].sz, 1'b0, 1'b0, '0);
            chk(r_err == VECS[v].err, "R3 error flag", r_err, VECS[v].err);
            if (VECS[v].err) begin
                chk(r_err_cs == 2'b00 && r_beats == 0, "R3 no select", r_err_cs, 0);
            end else begin
                chk(r_cs[0] == VECS[v].cs, "R1 R2 bank select", r_cs[0], VECS[v].cs);
                chk(r_lat[0] == int'(VECS[v].lat), "R4 R5 R6 latency", r_lat[0], VECS[v].lat);
                chk(r_ra[0] == exp_ra(VECS[v].addr, VECS[v].b32), "R10 rom address",
                    r_ra[0], exp_ra(VECS[v].addr, VECS[v].b32));
                chk(r_oe[0] == !VECS[v].wr && r_we[0] == VECS[v].wr, "R6 strobes",
                    {r_oe[0], r_we[0]}, {!VECS[v].wr, VECS[v].wr});
                chk(r_drop, "R12 release", rom_cs, 0);
            end
        end

        // R10: address bit 20 follows addr[22] only in 32-bit mode
        cfg_write(10'h000);
        bus32 = 1'b1;
        run_access(32'hFFC00006, 1'b0, 2'b01, 1'b0, 1'b0, '0);
        chk(r_ra[0] == 21'h100001, "R10 bus32 address", r_ra[0], 21'h100001);
        bus32 = 1'b0;
        run_access(32'hFFC00006, 1'b0, 2'b01, 1'b0, 1'b0, '0);
        chk(r_ra[0] == 21'h080000, "R10 bus64 address", r_ra[0], 21'h080000);

        // R7 R11 R12: burst with beat timing enabled, first wait 2, beat wait 1
        cfg_write(10'h222);
        run_access(32'hFF800068, 1'b0, 2'b10, 1'b1, 1'b0, '0);
        chk(r_beats == 4, "R7 beat count", r_beats, 4);
        chk(r_lat[0] == 5, "R7 first beat", r_lat[0], 5);
        for (int i = 1; i < 4; i++) chk(r_lat[i] == 3, "R7 later beat", r_lat[i], 3);
        for (int i = 0; i < 4; i++) begin
            chk(r_ra[i] == 21'(32'hC + i), "R11 beat address", r_ra[i], 32'hC + i);
            chk(r_last[i] == (i == 3), "R7 last flag", r_last[i], (i == 3));
        end
        chk(r_held, "R12 held across beats", r_held, 1);
        chk(r_drop, "R12 release after last", rom_cs, 0);

        // R8: burst with beat timing disabled
        cfg_write(10'h022);
        run_access(32'hFF000020, 1'b0, 2'b01, 1'b1, 1'b0, '0);
        chk(r_beats == 4, "R8 beat count", r_beats, 4);
        for (int i = 0; i < 4; i++) chk(r_lat[i] == 5, "R8 beat latency", r_lat[i], 5);
        chk(r_cs[3] == 2'b10, "R2 burst bank", r_cs[3], 2'b10);

        // R6: burst request on a write is one beat of 2 cycles
        run_access(32'hFF900000, 1'b1, 2'b01, 1'b1, 1'b0, '0);
        chk(r_beats == 1 && r_last[0], "R6 write single beat", r_beats, 1);
        chk(r_lat[0] == 2, "R6 write latency", r_lat[0], 2);

        // R13: configuration change during an access applies afterwards
        cfg_write(10'h000);
        run_access(32'hFF800000, 1'b0, 2'b01, 1'b0, 1'b1, 10'h00A);
        chk(r_lat[0] == 3, "R13 current access unchanged", r_lat[0], 3);
        chk(cfg_rdata == 10'h00A, "R13 register updated", cfg_rdata, 10'h00A);
        run_access(32'hFF800000, 1'b0, 2'b01, 1'b0, 1'b0, '0);
        chk(r_lat[0] == 13, "R13 next access uses new value", r_lat[0], 13);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule